// File: doc/BRIEF.md
# DDR Command Turnaround Timing Checker

A passive monitor that sits beside a DDR3 or DDR4 memory controller and watches the command stream after it has been decoded. Each cycle it sees at most one command, given as a kind (read, write or something else), a target (DIMM, rank within the DIMM, bank group) and a burst mode flag (BL8 or BC4). It keeps a short history of when each target last received a read and a write. When a new column command arrives sooner after an earlier one than the configured timing allows, the checker raises a one-cycle flag. The flag comes with a code that names the violated rule and the spacing it measured.

The required spacing comes from configuration inputs: CAS latency, CAS write latency, CAS-to-CAS delay, write-to-read delay, and four vendor-chosen minimums for turnarounds between ranks and between DIMMs. A mode input selects DDR3 scoping (same rank) or DDR4 scoping (same rank and bank group) for the write-to-read and write-to-write rules. History is held as saturating age counters rather than timestamps, so any idle period, however long, reads as "far enough".

The block has no state machine. It is a bank of age records, a small arithmetic stage that computes the minimums, and a priority scan. The scan's result is registered onto the outputs.

Top module: `ddr_turnaround_checker`

## Requirements
- R1: After reset all history is invalid and the outputs are low. The first command after reset raises no flag, and neither does the first command to a target with no earlier column command on any target.
- R2: A violation by the command presented in cycle k shows in cycle k+1 as `viol_valid`=1 for that one cycle. `viol_gap` is the number of clocks from the earlier command's cycle to the later one's. When `viol_valid`=0, `viol_code` and `viol_gap` are 0.
- R3: A write after a read to the same rank (code 1) needs a spacing of at least CL − CWL + 2 + CCD if that read was BL8, or CL − CWL + 2 + floor(CCD/2) if it was BC4. A negative result is treated as 0.
- R4: A read after a write to the same scope (code 4) needs a spacing of at least CWL + WTR + 4 if that write was BL8, or CWL + WTR + 2 if it was BC4. In DDR3 mode (`cfg_ddr4`=0) the scope is the rank. In DDR4 mode it is the rank plus bank group.
- R5: A write after a write to the same scope as in R4 (code 7) needs a spacing of at least CCD.
- R6: Between different ranks of the same DIMM, a read-then-write pair needs at least `cfg_rtw_rank` (code 2) and a write-then-read pair needs at least `cfg_wtr_rank` (code 5).
- R7: Between different DIMMs, a read-then-write pair needs at least `cfg_rtw_dimm` (code 3) and a write-then-read pair needs at least `cfg_wtr_dimm` (code 6).
- R8: A violation fires only when the spacing is strictly less than the minimum. A spacing equal to the minimum is legal.
- R9: Only one violation is reported per command. For a write the order is code 1, then 2, then 3, then 7. For a read it is code 4, then 5, then 6. Within codes 2, 3, 5 and 6, the earlier command on the lowest global rank (DIMM × ranks-per-DIMM + rank) wins.
- R10: Spacing saturates at 65535 clocks. After any idle stretch, even one longer than 65536 clocks, the next command raises no flag.
- R11: Command kinds 00 and 11 never flag and never update the history.
- R12: `cmd_kind` 01 is a read and 10 is a write. `cmd_bc4`=1 marks a BC4 burst and 0 marks BL8. The mode of the earlier command of a pair picks the formula.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_kind | input | 2 | 01 read, 10 write, 00/11 other |
| cmd_dimm | input | DIMM_W | Target DIMM |
| cmd_rank | input | RANK_W | Target rank within the DIMM |
| cmd_bg | input | BG_W | Target bank group |
| cmd_bc4 | input | 1 | 1 = BC4 burst, 0 = BL8 |
| cfg_ddr4 | input | 1 | 1 = bank-group scoping, 0 = rank scoping |
| cfg_cl | input | LAT_W | CAS latency in clocks |
| cfg_cwl | input | LAT_W | CAS write latency in clocks |
| cfg_ccd | input | LAT_W | CAS-to-CAS delay in clocks |
| cfg_wtr | input | LAT_W | Write-to-read delay in clocks |
| cfg_rtw_rank | input | LAT_W | Minimum read-to-write spacing across ranks |
| cfg_rtw_dimm | input | LAT_W | Minimum read-to-write spacing across DIMMs |
| cfg_wtr_rank | input | LAT_W | Minimum write-to-read spacing across ranks |
| cfg_wtr_dimm | input | LAT_W | Minimum write-to-read spacing across DIMMs |
| viol_valid | output | 1 | One-cycle violation flag |
| viol_code | output | 3 | Violated rule, codes 1 to 7 |
| viol_gap | output | CNT_W | Measured spacing in clocks |

## Verification
The bench aims at the exact boundary of each rule, where the spacing equals the minimum. A design that compares with ≤ instead of < flags legal traffic there. It issues a write one cycle after a read with CL far below CWL. A design that forgets the clamp to zero wraps the minimum to a huge value and flags everything. It also places a write 65538 clocks after a read. A timestamp counter that wraps sees a gap of 2 and flags falsely.

Further directed cases cover priority between several violated rules, DDR4 bank-group scoping and BC4 formulas taken from the earlier command. A design that scopes by rank only would flag a read to another bank group. A design that takes the burst mode from the later command would get the BC4 minimum wrong. Seeded random traffic across all targets, with reconfigured latencies, is compared against a bench model of every rule.

// File: rtl/ddr_tat_pkg.sv
package ddr_tat_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10,
        CMD_MISC  = 2'b11
    } cmd_kind_e;

    typedef enum logic [2:0] {
        VC_NONE     = 3'd0,
        VC_RTW_SAME = 3'd1,
        VC_RTW_RANK = 3'd2,
        VC_RTW_DIMM = 3'd3,
        VC_WTR_SAME = 3'd4,
        VC_WTR_RANK = 3'd5,
        VC_WTR_DIMM = 3'd6,
        VC_WTW      = 3'd7
    } viol_code_e;

endpackage

// File: rtl/tat_age_bank.sv
// Bank of saturating age records; gap reads as clocks since the hit cycle.
module tat_age_bank #(
    parameter int N     = 4,
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N-1:0]              hit,
    input  logic                      tag_in,
    output logic [N-1:0]              valid,
    output logic [N-1:0]              tag,
    output logic [N-1:0][CNT_W-1:0]   gap
);

    localparam logic [CNT_W-1:0] AGE_MAX = '1;

    for (genvar i = 0; i < N; i++) begin : g_rec
        logic [CNT_W-1:0] age;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid[i] <= 1'b0;
                tag[i]   <= 1'b0;
                age      <= '0;
            end else if (hit[i]) begin
                valid[i] <= 1'b1;
                tag[i]   <= tag_in;
                age      <= '0;
            end else if (valid[i] && age != AGE_MAX) begin
                age <= age + CNT_W'(1);
            end
        end

        // age 0 is visible one cycle after the hit, so spacing is age + 1
        assign gap[i] = (age == AGE_MAX) ? AGE_MAX : age + CNT_W'(1);
    end

endmodule

// File: rtl/tat_min_calc.sv
// Same-scope minimum spacings for both burst modes.
module tat_min_calc #(
    parameter int LAT_W = 8,
    parameter int CNT_W = 16
) (
    input  logic [LAT_W-1:0] cfg_cl,
    input  logic [LAT_W-1:0] cfg_cwl,
    input  logic [LAT_W-1:0] cfg_ccd,
    input  logic [LAT_W-1:0] cfg_wtr,
    output logic [CNT_W-1:0] rtw_bl8,
    output logic [CNT_W-1:0] rtw_bc4,
    output logic [CNT_W-1:0] wtr_bl8,
    output logic [CNT_W-1:0] wtr_bc4
);

    localparam int SW = CNT_W + 2;

    logic [SW-1:0] rtw_base, rtw8_raw, rtw4_raw;

    always_comb begin
        rtw_base = SW'(cfg_cl) - SW'(cfg_cwl) + SW'(2);
        rtw8_raw = rtw_base + SW'(cfg_ccd);
        rtw4_raw = rtw_base + SW'(cfg_ccd >> 1);
        // top bit set means the difference went negative: clamp to zero
        rtw_bl8  = rtw8_raw[SW-1] ? '0 : rtw8_raw[CNT_W-1:0];
        rtw_bc4  = rtw4_raw[SW-1] ? '0 : rtw4_raw[CNT_W-1:0];
        wtr_bl8  = CNT_W'(cfg_cwl) + CNT_W'(cfg_wtr) + CNT_W'(4);
        wtr_bc4  = CNT_W'(cfg_cwl) + CNT_W'(cfg_wtr) + CNT_W'(2);
    end

endmodule

// File: rtl/ddr_turnaround_checker.sv
module ddr_turnaround_checker
    import ddr_tat_pkg::*;
#(
    parameter int DIMM_W = 1,
    parameter int RANK_W = 1,
    parameter int BG_W   = 2,
    parameter int LAT_W  = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cmd_kind,
    input  logic [DIMM_W-1:0] cmd_dimm,
    input  logic [RANK_W-1:0] cmd_rank,
    input  logic [BG_W-1:0]   cmd_bg,
    input  logic              cmd_bc4,
    input  logic              cfg_ddr4,
    input  logic [LAT_W-1:0]  cfg_cl,
    input  logic [LAT_W-1:0]  cfg_cwl,
    input  logic [LAT_W-1:0]  cfg_ccd,
    input  logic [LAT_W-1:0]  cfg_wtr,
    input  logic [LAT_W-1:0]  cfg_rtw_rank,
    input  logic [LAT_W-1:0]  cfg_rtw_dimm,
    input  logic [LAT_W-1:0]  cfg_wtr_rank,
    input  logic [LAT_W-1:0]  cfg_wtr_dimm,
    output logic              viol_valid,
    output logic [2:0]        viol_code,
    output logic [CNT_W-1:0]  viol_gap
);

    localparam int GR_W  = DIMM_W + RANK_W;
    localparam int NRANK = 1 << GR_W;
    localparam int NRBG  = 1 << (GR_W + BG_W);

    cmd_kind_e kind;
    assign kind = cmd_kind_e'(cmd_kind);

    logic [GR_W-1:0]      grank;
    logic [GR_W+BG_W-1:0] rbg;
    assign grank = {cmd_dimm, cmd_rank};
    assign rbg   = {cmd_dimm, cmd_rank, cmd_bg};

    logic is_rd, is_wr;
    assign is_rd = (kind == CMD_READ);
    assign is_wr = (kind == CMD_WRITE);

    // ---------------- history records ----------------
    logic [NRANK-1:0]            rd_v, rd_t, wr_v, wr_t;
    logic [NRANK-1:0][CNT_W-1:0] rd_g, wr_g;
    logic [NRBG-1:0]             bw_v, bw_t;
    logic [NRBG-1:0][CNT_W-1:0]  bw_g;

    logic [NRANK-1:0] rd_hit, wr_hit;
    logic [NRBG-1:0]  bw_hit;
    assign rd_hit = is_rd ? (NRANK'(1) << grank) : '0;
    assign wr_hit = is_wr ? (NRANK'(1) << grank) : '0;
    assign bw_hit = is_wr ? (NRBG'(1) << rbg)    : '0;

    tat_age_bank #(.N(NRANK), .CNT_W(CNT_W)) u_rd_hist (
        .clk(clk), .rst_n(rst_n), .hit(rd_hit), .tag_in(cmd_bc4),
        .valid(rd_v), .tag(rd_t), .gap(rd_g));

    tat_age_bank #(.N(NRANK), .CNT_W(CNT_W)) u_wr_hist (
        .clk(clk), .rst_n(rst_n), .hit(wr_hit), .tag_in(cmd_bc4),
        .valid(wr_v), .tag(wr_t), .gap(wr_g));

    tat_age_bank #(.N(NRBG), .CNT_W(CNT_W)) u_bg_hist (
        .clk(clk), .rst_n(rst_n), .hit(bw_hit), .tag_in(cmd_bc4),
        .valid(bw_v), .tag(bw_t), .gap(bw_g));

    // ---------------- minimum spacings ----------------
    logic [CNT_W-1:0] rtw_bl8, rtw_bc4, wtr_bl8, wtr_bc4;

    tat_min_calc #(.LAT_W(LAT_W), .CNT_W(CNT_W)) u_min (
        .cfg_cl(cfg_cl), .cfg_cwl(cfg_cwl), .cfg_ccd(cfg_ccd), .cfg_wtr(cfg_wtr),
        .rtw_bl8(rtw_bl8), .rtw_bc4(rtw_bc4), .wtr_bl8(wtr_bl8), .wtr_bc4(wtr_bc4));

    // same-scope write record: rank in DDR3 mode, rank+bank group in DDR4 mode
    logic             sw_v, sw_t;
    logic [CNT_W-1:0] sw_g;
    assign sw_v = cfg_ddr4 ? bw_v[rbg] : wr_v[grank];
    assign sw_t = cfg_ddr4 ? bw_t[rbg] : wr_t[grank];
    assign sw_g = cfg_ddr4 ? bw_g[rbg] : wr_g[grank];

    // ---------------- priority scan ----------------
    // later assignments override earlier ones, so the scan runs from the
    // lowest priority up and ranks from high index down
    viol_code_e       code_n;
    logic [CNT_W-1:0] gap_n;

    always_comb begin
        code_n = VC_NONE;
        gap_n  = '0;
        unique case (kind)
            CMD_WRITE: begin
                if (sw_v && sw_g < CNT_W'(cfg_ccd)) begin
                    code_n = VC_WTW;
                    gap_n  = sw_g;
                end
                for (int j = NRANK - 1; j >= 0; j--) begin
                    if ((j >> RANK_W) != int'(cmd_dimm) && rd_v[j]
                        && rd_g[j] < CNT_W'(cfg_rtw_dimm)) begin
                        code_n = VC_RTW_DIMM;
                        gap_n  = rd_g[j];
                    end
                end
                for (int j = NRANK - 1; j >= 0; j--) begin
                    if ((j >> RANK_W) == int'(cmd_dimm) && j != int'(grank) && rd_v[j]
                        && rd_g[j] < CNT_W'(cfg_rtw_rank)) begin
                        code_n = VC_RTW_RANK;
                        gap_n  = rd_g[j];
                    end
                end
                if (rd_v[grank] && rd_g[grank] < (rd_t[grank] ? rtw_bc4 : rtw_bl8)) begin
                    code_n = VC_RTW_SAME;
                    gap_n  = rd_g[grank];
                end
            end
            CMD_READ: begin
                for (int j = NRANK - 1; j >= 0; j--) begin
                    if ((j >> RANK_W) != int'(cmd_dimm) && wr_v[j]
                        && wr_g[j] < CNT_W'(cfg_wtr_dimm)) begin
                        code_n = VC_WTR_DIMM;
                        gap_n  = wr_g[j];
                    end
                end
                for (int j = NRANK - 1; j >= 0; j--) begin
                    if ((j >> RANK_W) == int'(cmd_dimm) && j != int'(grank) && wr_v[j]
                        && wr_g[j] < CNT_W'(cfg_wtr_rank)) begin
                        code_n = VC_WTR_RANK;
                        gap_n  = wr_g[j];
                    end
                end
                if (sw_v && sw_g < (sw_t ? wtr_bc4 : wtr_bl8)) begin
                    code_n = VC_WTR_SAME;
                    gap_n  = sw_g;
                end
            end
            default: begin
                code_n = VC_NONE;
                gap_n  = '0;
            end
        endcase
    end

    // ---------------- output register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            viol_valid <= 1'b0;
            viol_code  <= 3'd0;
            viol_gap   <= '0;
        end else begin
            viol_valid <= (code_n != VC_NONE);
            viol_code  <= code_n;
            viol_gap   <= gap_n;
        end
    end

endmodule

// File: rtl/tat_checker.sv
module tat_checker #(
    parameter int LAT_W = 8,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cmd_kind,
    input logic [LAT_W-1:0] cfg_ccd,
    input logic [LAT_W-1:0] cfg_rtw_rank,
    input logic [LAT_W-1:0] cfg_rtw_dimm,
    input logic [LAT_W-1:0] cfg_wtr_rank,
    input logic [LAT_W-1:0] cfg_wtr_dimm,
    input logic             viol_valid,
    input logic [2:0]       viol_code,
    input logic [CNT_W-1:0] viol_gap
);

    a_r2_quiet_when_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_valid |-> (viol_code == 3'd0 && viol_gap == '0));

    a_r2_flag_has_code: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> (viol_code != 3'd0 && viol_gap != '0));

    a_r11_flag_needs_column: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid |-> ($past(cmd_kind) == 2'b01 || $past(cmd_kind) == 2'b10));

    a_r9_write_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && (viol_code == 3'd1 || viol_code == 3'd2 || viol_code == 3'd3
                        || viol_code == 3'd7)) |-> $past(cmd_kind) == 2'b10);

    a_r9_read_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && (viol_code == 3'd4 || viol_code == 3'd5 || viol_code == 3'd6))
        |-> $past(cmd_kind) == 2'b01);

    a_r5_wtw_below_ccd: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && viol_code == 3'd7) |-> viol_gap < CNT_W'($past(cfg_ccd)));

    a_r6_rtw_rank_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && viol_code == 3'd2) |-> viol_gap < CNT_W'($past(cfg_rtw_rank)));

    a_r6_wtr_rank_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && viol_code == 3'd5) |-> viol_gap < CNT_W'($past(cfg_wtr_rank)));

    a_r7_rtw_dimm_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && viol_code == 3'd3) |-> viol_gap < CNT_W'($past(cfg_rtw_dimm)));

    a_r7_wtr_dimm_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid && viol_code == 3'd6) |-> viol_gap < CNT_W'($past(cfg_wtr_dimm)));

endmodule

bind ddr_turnaround_checker tat_checker #(.LAT_W(LAT_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_kind(cmd_kind), .cfg_ccd(cfg_ccd),
    .cfg_rtw_rank(cfg_rtw_rank), .cfg_rtw_dimm(cfg_rtw_dimm),
    .cfg_wtr_rank(cfg_wtr_rank), .cfg_wtr_dimm(cfg_wtr_dimm),
    .viol_valid(viol_valid), .viol_code(viol_code), .viol_gap(viol_gap));

// File: tb/sim_ddr_turnaround_checker.sv
`timescale 1ns/1ps
module sim_ddr_turnaround_checker;

    localparam int NR   = 4;
    localparam int NRBG = 16;
    localparam longint SAT = 65535;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cmd_kind;
    logic [0:0] cmd_dimm, cmd_rank;
    logic [1:0] cmd_bg;
    logic       cmd_bc4, cfg_ddr4;
    logic [7:0] cfg_cl, cfg_cwl, cfg_ccd, cfg_wtr;
    logic [7:0] cfg_rtw_rank, cfg_rtw_dimm, cfg_wtr_rank, cfg_wtr_dimm;
    logic        viol_valid;
    logic [2:0]  viol_code;
    logic [15:0] viol_gap;

    always #10 clk = ~clk;

    ddr_turnaround_checker u0 (
        .clk(clk), .rst_n(rst_n), .cmd_kind(cmd_kind), .cmd_dimm(cmd_dimm),
        .cmd_rank(cmd_rank), .cmd_bg(cmd_bg), .cmd_bc4(cmd_bc4), .cfg_ddr4(cfg_ddr4),
        .cfg_cl(cfg_cl), .cfg_cwl(cfg_cwl), .cfg_ccd(cfg_ccd), .cfg_wtr(cfg_wtr),
        .cfg_rtw_rank(cfg_rtw_rank), .cfg_rtw_dimm(cfg_rtw_dimm),
        .cfg_wtr_rank(cfg_wtr_rank), .cfg_wtr_dimm(cfg_wtr_dimm),
        .viol_valid(viol_valid), .viol_code(viol_code), .viol_gap(viol_gap));

    int n_checks = 0;
    int n_fail   = 0;

    // bench model of history
    longint cyc = 0;
    longint rd_c[NR], wr_c[NR], bw_c[NRBG];
    bit     rd_ok[NR], wr_ok[NR], bw_ok[NRBG];
    bit     rd_b[NR], wr_b[NR], bw_b[NRBG];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic longint gapf(input longint t);
        return (cyc - t > SAT) ? SAT : cyc - t;
    endfunction

    function automatic string req_of(input int c);
        case (c)
            1: return "R3";
            2, 5: return "R6";
            3, 6: return "R7";
            4: return "R4";
            7: return "R5";
            default: return "R2";
        endcase
    endfunction

    function automatic longint rtw_min(input bit bc);
        longint v = longint'(cfg_cl) - longint'(cfg_cwl) + 2
                    + (bc ? longint'(cfg_ccd) / 2 : longint'(cfg_ccd));
        return (v < 0) ? 0 : v;
    endfunction

    function automatic longint wtr_min(input bit bc);
        return longint'(cfg_cwl) + longint'(cfg_wtr) + (bc ? 2 : 4);
    endfunction

    task automatic expect_of(input int k, input int d, input int r, input int b,
                             output int ec, output longint eg);
        int g = d * 2 + r;
        int x = g * 4 + b;
        bit sv; bit sb; longint sg;
        ec = 0; eg = 0;
        sv = cfg_ddr4 ? bw_ok[x] : wr_ok[g];
        sb = cfg_ddr4 ? bw_b[x]  : wr_b[g];
        sg = cfg_ddr4 ? gapf(bw_c[x]) : gapf(wr_c[g]);
        if (k == 2) begin
            if (rd_ok[g] && gapf(rd_c[g]) < rtw_min(rd_b[g])) begin
                ec = 1; eg = gapf(rd_c[g]); return;
            end
            for (int j = 0; j < NR; j++)
                if (j / 2 == d && j != g && rd_ok[j] && gapf(rd_c[j]) < longint'(cfg_rtw_rank)) begin
                    ec = 2; eg = gapf(rd_c[j]); return;
                end
            for (int j = 0; j < NR; j++)
                if (j / 2 != d && rd_ok[j] && gapf(rd_c[j]) < longint'(cfg_rtw_dimm)) begin
                    ec = 3; eg = gapf(rd_c[j]); return;
                end
            if (sv && sg < longint'(cfg_ccd)) begin
                ec = 7; eg = sg; return;
            end
        end else if (k == 1) begin
            if (sv && sg < wtr_min(sb)) begin
                ec = 4; eg = sg; return;
            end
            for (int j = 0; j < NR; j++)
                if (j / 2 == d && j != g && wr_ok[j] && gapf(wr_c[j]) < longint'(cfg_wtr_rank)) begin
                    ec = 5; eg = gapf(wr_c[j]); return;
                end
            for (int j = 0; j < NR; j++)
                if (j / 2 != d && wr_ok[j] && gapf(wr_c[j]) < longint'(cfg_wtr_dimm)) begin
                    ec = 6; eg = gapf(wr_c[j]); return;
                end
        end
    endtask

    // one command cycle: drive at negedge, check outputs at the next negedge
    task automatic issue(input int k, input int d, input int r, input int b,
                         input bit bc, input string tag);
        int ec; longint eg; string t;
        int g = d * 2 + r;
        expect_of(k, d, r, b, ec, eg);
        cmd_kind = 2'(k); cmd_dimm = 1'(d); cmd_rank = 1'(r);
        cmd_bg = 2'(b); cmd_bc4 = bc;
        if (k == 1) begin rd_ok[g] = 1; rd_c[g] = cyc; rd_b[g] = bc; end
        if (k == 2) begin
            wr_ok[g] = 1; wr_c[g] = cyc; wr_b[g] = bc;
            bw_ok[g*4+b] = 1; bw_c[g*4+b] = cyc; bw_b[g*4+b] = bc;
        end
        @(negedge clk);
        cyc++;
        t = (tag == "") ? req_of(ec) : tag;
        chk(viol_valid == (ec != 0), t, viol_valid, ec != 0);
        chk(int'(viol_code) == ec, t, viol_code, ec);
        chk(longint'(viol_gap) == eg, t, viol_gap, eg);
    endtask

    task automatic idle(input int n);
        cmd_kind = 2'b00;
        repeat (n) @(negedge clk);
        cyc += n;
    endtask

    // hand-computed expectation on the outputs of the last command
    task automatic want(input int code, input int gap, input string tag);
        chk(int'(viol_code) == code, tag, viol_code, code);
        chk(int'(viol_gap) == gap, tag, viol_gap, gap);
    endtask

    task automatic base_cfg();
        cfg_ddr4 = 0; cfg_cl = 11; cfg_cwl = 8; cfg_ccd = 4; cfg_wtr = 6;
        cfg_rtw_rank = 3; cfg_rtw_dimm = 5; cfg_wtr_rank = 4; cfg_wtr_dimm = 6;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        rst_n = 0; cmd_kind = 0; cmd_dimm = 0; cmd_rank = 0; cmd_bg = 0; cmd_bc4 = 0;
        base_cfg();
        for (int i = 0; i < NR; i++) begin rd_ok[i] = 0; wr_ok[i] = 0; end
        for (int i = 0; i < NRBG; i++) bw_ok[i] = 0;
        repeat (4) @(negedge clk);
        chk(viol_valid == 0, "R1", viol_valid, 0);
        want(0, 0, "R1");
        rst_n = 1;

        // R1: first command after reset
        issue(2, 0, 0, 0, 0, "R1"); want(0, 0, "R1");

        // R8 boundary and R3 BL8 violation (min 9)
        idle(40); issue(1, 0, 0, 0, 0, ""); idle(8); issue(2, 0, 0, 0, 0, "R8"); want(0, 0, "R8");
        idle(40); issue(1, 0, 0, 0, 0, ""); idle(7); issue(2, 0, 0, 0, 0, "R3"); want(1, 8, "R3");
        idle(1);
        chk(viol_valid == 0, "R2", viol_valid, 0);

        // R12: BC4 read gives min 7
        idle(40); issue(1, 0, 0, 0, 1, ""); idle(5); issue(2, 0, 0, 0, 0, "R12"); want(1, 6, "R12");

        // R4 DDR3 rank scope (min 18)
        idle(40); issue(2, 0, 0, 0, 0, ""); idle(9); issue(1, 0, 0, 1, 0, "R4"); want(4, 10, "R4");
        // R4 DDR4 bank-group scope
        cfg_ddr4 = 1;
        idle(40); issue(2, 0, 0, 0, 0, ""); idle(9); issue(1, 0, 0, 1, 0, "R4"); want(0, 0, "R4");
        idle(40); issue(2, 0, 0, 2, 1, ""); idle(14); issue(1, 0, 0, 2, 0, "R4"); want(4, 15, "R4");
        cfg_ddr4 = 0;

        // R5 write to write
        idle(40); issue(2, 1, 0, 0, 0, ""); idle(2); issue(2, 1, 0, 0, 0, "R5"); want(7, 3, "R5");

        // R6 cross-rank
        idle(40); issue(1, 0, 0, 0, 0, ""); idle(1); issue(2, 0, 1, 0, 0, "R6"); want(2, 2, "R6");
        idle(40); issue(2, 1, 1, 0, 0, ""); idle(2); issue(1, 1, 0, 0, 0, "R6"); want(5, 3, "R6");

        // R7 cross-DIMM
        idle(40); issue(1, 0, 1, 0, 0, ""); idle(3); issue(2, 1, 0, 0, 0, "R7"); want(3, 4, "R7");
        idle(40); issue(2, 0, 0, 0, 0, ""); idle(4); issue(1, 1, 1, 0, 0, "R7"); want(6, 5, "R7");

        // R9 priority
        idle(40); issue(1, 0, 0, 0, 0, ""); issue(1, 0, 1, 0, 0, "");
        issue(2, 0, 0, 0, 0, "R9"); want(1, 2, "R9");
        idle(40); issue(1, 1, 1, 0, 0, ""); issue(1, 1, 0, 0, 0, "");
        issue(2, 0, 0, 0, 0, "R9"); want(3, 1, "R9");

        // R11 non-column commands
        idle(40); issue(1, 0, 0, 0, 0, ""); issue(3, 0, 0, 0, 0, "R11"); want(0, 0, "R11");
        idle(1); issue(2, 0, 0, 0, 0, "R11"); want(1, 3, "R11");

        // R10 idle past counter wrap
        idle(40); issue(1, 0, 0, 0, 0, ""); idle(65537);
        issue(2, 0, 0, 0, 0, "R10"); want(0, 0, "R10");

        // R3 negative minimum clamps to zero
        cfg_cl = 5; cfg_cwl = 16;
        idle(40); issue(1, 0, 0, 0, 0, ""); issue(2, 0, 0, 0, 0, "R3"); want(0, 0, "R3");
        base_cfg();

        // seeded random traffic
        for (int i = 0; i < 3000; i++) begin
            if (i % 500 == 0) begin
                idle(30);
                cfg_ddr4 = 1'($urandom_range(0, 1));
                cfg_cl = 8'($urandom_range(5, 20)); cfg_cwl = 8'($urandom_range(5, 16));
                cfg_ccd = 8'($urandom_range(4, 8)); cfg_wtr = 8'($urandom_range(2, 8));
                cfg_rtw_rank = 8'($urandom_range(1, 10)); cfg_rtw_dimm = 8'($urandom_range(1, 10));
                cfg_wtr_rank = 8'($urandom_range(1, 10)); cfg_wtr_dimm = 8'($urandom_range(1, 10));
            end
            idle(int'($urandom_range(0, 10)));
            begin
                int sel = int'($urandom_range(0, 9));
                int k = (sel < 4) ? 1 : (sel < 8) ? 2 : ((sel == 8) ? 0 : 3);
                issue(k, int'($urandom_range(0, 1)), int'($urandom_range(0, 1)),
                      int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "");
            end
        end
        idle(5);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule